// File: doc/BRIEF.md
# Atomic Operation Placement Router

This block decides where one atomic memory operation runs and reports that decision to the unit that carries it out. Each request gives the kind of atomic (load-atomic or store-atomic), the memory attribute of its target, the result of the private data-cache lookup with its coherence state, and whether the line is held anywhere in the cluster and whether it is already in the shared third-level cache. Two static configuration bits describe the system port: whether it is a coherent hub-style master, and whether the interconnect can execute atomics.

A cacheable atomic that owns its line in the private cache runs there. Otherwise it runs at the shared L3. It is passed out to the interconnect only when nothing in the cluster holds the line and both configuration bits allow it. When L3 runs the atomic on a line it does not yet hold, the response also tells L3 to allocate the line. An atomic to device or non-cacheable memory goes to the interconnect when the interconnect supports atomics. If it does not, a load-atomic gets a synchronous abort in its response. A store-atomic gets an asynchronous abort, which also sets a sticky pending flag that stays set until it is acknowledged.

Each decision is registered once and handed on through a valid/ready handshake. The response is held steady until the consumer takes it.

Top module: `atomic_router`

## Requirements
- R1: A cacheable request (attr 2'b00) with an L1 hit in unique state yields destination bit 0 (near, L1).
- R2: A cacheable request without a unique L1 hit yields destination bit 1 (far, L3) when the line is held in the cluster (L1 hit or cluster hit), or when either configuration bit is clear.
- R3: A cacheable request without an L1 hit and without a cluster hit yields destination bit 2 (interconnect) when both the hub-master bit and the interconnect-atomics bit are set.
- R4: The L3-allocate flag is set exactly when the destination is L3 and the request reported the line as not present in L3.
- R5: A device (2'b01) or non-cacheable (2'b10 or 2'b11) request yields destination bit 2 when the interconnect-atomics bit is set, whatever the hub-master bit is.
- R6: A device or non-cacheable load-atomic without interconnect atomic support yields the synchronous abort bit in its response and no destination.
- R7: A device or non-cacheable store-atomic without interconnect atomic support yields the asynchronous abort bit in its response. It also sets the pending flag one cycle after acceptance. The flag then stays set until an acknowledge clears it, and a new set in the same cycle as an acknowledge wins.
- R8: Every response has exactly one of the five bits set: the three destination bits, the synchronous abort and the asynchronous abort.
- R9: While the response is valid and not ready, the response and all its fields stay unchanged. A request is accepted only when no response is pending or the pending one is taken in the same cycle.
- R10: After reset, no response is valid and the pending flag is clear.
- R11: The response for an accepted request is valid on the clock edge that follows acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_store | input | 1 | 1 store-atomic, 0 load-atomic |
| req_attr | input | 2 | 00 cacheable, 01 device, 10/11 non-cacheable |
| l1_hit | input | 1 | Line found in private L1 |
| l1_unique | input | 1 | L1 line held in unique state |
| clu_hit | input | 1 | Line held elsewhere in the cluster |
| clu_in_l3 | input | 1 | Line already present in L3 |
| cfg_hub_master | input | 1 | System port is a coherent hub master |
| cfg_ic_atomics | input | 1 | Interconnect executes atomics |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_dest | output | 3 | One-hot: bit0 L1, bit1 L3, bit2 interconnect |
| rsp_l3_alloc | output | 1 | L3 must allocate the line |
| rsp_sync_abort | output | 1 | Synchronous abort for this request |
| rsp_async_abort | output | 1 | Request raised an asynchronous abort |
| async_pending | output | 1 | Sticky asynchronous abort flag |
| async_ack | input | 1 | Clears the pending flag |

## Verification
Every response field is due one clock after the accepting edge. The pending flag also rises one clock after the edge that accepts the aborting store, and it falls one clock after an acknowledge edge. The bench drives inputs on the falling edge and advances a behavioural model on each rising edge, using the same input values the design sees there. It compares every output just before the next rising edge, so the expected and actual values always belong to the same cycle. Directed sequences cover stalls with ready held low, as well as an acknowledge that arrives in the same cycle as a new abort.

// File: rtl/atom_pkg.sv
package atom_pkg;
    localparam int DEST_W   = 3;
    localparam int DEST_L1  = 0;
    localparam int DEST_L3  = 1;
    localparam int DEST_IC  = 2;
    localparam int ATTR_W   = 2;

    typedef enum logic [ATTR_W-1:0] {
        ATTR_CACHEABLE = 2'b00,
        ATTR_DEVICE    = 2'b01,
        ATTR_NONCACHE  = 2'b10,
        ATTR_NONCACHE2 = 2'b11
    } atom_attr_e;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              l3_alloc;
        logic              sync_ab;
        logic              async_ab;
    } atom_rsp_t;
endpackage

// File: rtl/atom_place_dec.sv
module atom_place_dec
    import atom_pkg::*;
(
    input  logic              is_store,
    input  logic [ATTR_W-1:0] attr,
    input  logic              l1_hit,
    input  logic              l1_unique,
    input  logic              clu_hit,
    input  logic              clu_in_l3,
    input  logic              cfg_hub,
    input  logic              cfg_ic,
    output atom_rsp_t         dec
);
    logic cacheable;
    logic near_ok;
    logic anywhere;
    logic ic_far_ok;

    always_comb begin
        cacheable = (attr == ATTR_CACHEABLE);
        near_ok   = l1_hit && l1_unique;
        anywhere  = l1_hit || clu_hit;
        ic_far_ok = !anywhere && cfg_hub && cfg_ic;
        dec       = '0;
        if (cacheable) begin
            if (near_ok) begin
                dec.dest[DEST_L1] = 1'b1;
            end else if (ic_far_ok) begin
                dec.dest[DEST_IC] = 1'b1;
            end else begin
                dec.dest[DEST_L3] = 1'b1;
                dec.l3_alloc      = !clu_in_l3;
            end
        end else if (cfg_ic) begin
            dec.dest[DEST_IC] = 1'b1;
        end else if (is_store) begin
            dec.async_ab = 1'b1;
        end else begin
            dec.sync_ab = 1'b1;
        end
    end

    // R8
    always_comb begin
        dec_onehot_chk: assert ($countones({dec.dest, dec.sync_ab, dec.async_ab}) == 1 || $isunknown(attr));
    end
endmodule

// File: rtl/atom_abort_flag.sv
module atom_abort_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    output logic pend_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = pend_q;
        if (ack_i) pend_d = 1'b0;
        if (set_i) pend_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);
    // R7
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && ack_i) |=> !pend_o);
    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !ack_i) |=> $stable(pend_o));
endmodule

// File: rtl/atomic_router.sv
module atomic_router
    import atom_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_store,
    input  logic [ATTR_W-1:0] req_attr,
    input  logic              l1_hit,
    input  logic              l1_unique,
    input  logic              clu_hit,
    input  logic              clu_in_l3,
    input  logic              cfg_hub_master,
    input  logic              cfg_ic_atomics,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DEST_W-1:0] rsp_dest,
    output logic              rsp_l3_alloc,
    output logic              rsp_sync_abort,
    output logic              rsp_async_abort,
    output logic              async_pending,
    input  logic              async_ack
);
    typedef struct packed {
        logic      vld;
        atom_rsp_t rsp;
    } stage_t;

    stage_t    st_d, st_q;
    atom_rsp_t dec;
    logic      accept;

    atom_place_dec u_dec (
        .is_store  (req_is_store),
        .attr      (req_attr),
        .l1_hit    (l1_hit),
        .l1_unique (l1_unique),
        .clu_hit   (clu_hit),
        .clu_in_l3 (clu_in_l3),
        .cfg_hub   (cfg_hub_master),
        .cfg_ic    (cfg_ic_atomics),
        .dec       (dec)
    );

    always_comb begin
        req_ready = !st_q.vld || rsp_ready;
        accept    = req_valid && req_ready;
        st_d      = st_q;
        if (st_q.vld && rsp_ready) st_d.vld = 1'b0;
        if (accept) begin
            st_d.vld = 1'b1;
            st_d.rsp = dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    atom_abort_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (accept && dec.async_ab),
        .ack_i  (async_ack),
        .pend_o (async_pending)
    );

    assign rsp_valid       = st_q.vld;
    assign rsp_dest        = st_q.rsp.dest;
    assign rsp_l3_alloc    = st_q.rsp.l3_alloc;
    assign rsp_sync_abort  = st_q.rsp.sync_ab;
    assign rsp_async_abort = st_q.rsp.async_ab;

    // R8
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_dest, rsp_sync_abort, rsp_async_abort}) == 1);
    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_dest, rsp_l3_alloc,
                                        rsp_sync_abort, rsp_async_abort})));
    // R4
    alloc_l3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_l3_alloc) |-> rsp_dest[DEST_L3]);
    // R11
    accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);
    // R6
    cache_noabort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_attr == ATTR_CACHEABLE) |=> !(rsp_sync_abort || rsp_async_abort));
endmodule

// File: tb/sim_atomic_router.sv
`timescale 1ns/1ps
module sim_atomic_router;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 0, req_is_store = 0;
    logic [1:0] req_attr = 0;
    logic       l1_hit = 0, l1_unique = 0, clu_hit = 0, clu_in_l3 = 0;
    logic       cfg_hub_master = 0, cfg_ic_atomics = 0;
    logic       rsp_ready = 0, async_ack = 0;
    logic       req_ready, rsp_valid, rsp_l3_alloc, rsp_sync_abort, rsp_async_abort, async_pending;
    logic [2:0] rsp_dest;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // reference model state
    bit         m_vld = 0;
    logic [5:0] m_rsp = '0;   // {dest[2:0], alloc, sync, async}
    string      m_tag = "R10";
    bit         m_pend = 0;

    always #2.5 clk = ~clk;

    atomic_router u0 (
        .clk, .rst_n, .req_valid, .req_ready, .req_is_store, .req_attr,
        .l1_hit, .l1_unique, .clu_hit, .clu_in_l3, .cfg_hub_master,
        .cfg_ic_atomics, .rsp_valid, .rsp_ready, .rsp_dest, .rsp_l3_alloc,
        .rsp_sync_abort, .rsp_async_abort, .async_pending, .async_ack
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [5:0] expect_rsp(output string tag);
        logic [2:0] d = 3'b000;
        logic al = 0, sy = 0, as = 0;
        if (req_attr == 2'b00) begin
            if (l1_hit && l1_unique) begin d = 3'b001; tag = "R1"; end
            else if (!l1_hit && !clu_hit && cfg_hub_master && cfg_ic_atomics) begin
                d = 3'b100; tag = "R3";
            end else begin
                d = 3'b010; al = !clu_in_l3; tag = "R2_R4";
            end
        end else if (cfg_ic_atomics) begin d = 3'b100; tag = "R5"; end
        else if (req_is_store) begin as = 1; tag = "R7"; end
        else begin sy = 1; tag = "R6"; end
        return {d, al, sy, as};
    endfunction

    task automatic compare();
        chk("R9 req_ready", 8'(req_ready), 8'(!m_vld || rsp_ready));
        chk({"R11 rsp_valid ", m_tag}, 8'(rsp_valid), 8'(m_vld));
        if (m_vld) begin
            chk({m_tag, " dest"}, 8'(rsp_dest), 8'(m_rsp[5:3]));
            chk({m_tag, " R4 alloc"}, 8'(rsp_l3_alloc), 8'(m_rsp[2]));
            chk({m_tag, " R8 aborts"}, 8'({rsp_sync_abort, rsp_async_abort}), 8'(m_rsp[1:0]));
        end
        chk("R7 pending", 8'(async_pending), 8'(m_pend));
    endtask

    // one cycle: inputs already driven at negedge; check, then advance model at posedge
    task automatic step();
        bit acc;
        logic [5:0] nr;
        string t;
        #1 compare();
        @(posedge clk);
        acc = req_valid && (!m_vld || rsp_ready);
        nr = expect_rsp(t);
        if (m_vld && rsp_ready) m_vld = 0;
        if (async_ack) m_pend = 0;
        if (acc) begin
            m_vld = 1; m_rsp = nr; m_tag = t;
            if (nr[0]) m_pend = 1;
        end
        @(negedge clk);
    endtask

    task automatic drive(input bit v, input bit st, input logic [1:0] at, input bit h,
                         input bit u, input bit ch, input bit in3, input bit hub,
                         input bit ic, input bit rr, input bit ack);
        req_valid = v; req_is_store = st; req_attr = at; l1_hit = h; l1_unique = u;
        clu_hit = ch; clu_in_l3 = in3; cfg_hub_master = hub; cfg_ic_atomics = ic;
        rsp_ready = rr; async_ack = ack;
        step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10 reset state
        #1 chk("R10 rsp_valid", 8'(rsp_valid), 8'(0));
        chk("R10 pending", 8'(async_pending), 8'(0));
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // directed: R1 near
        drive(1,0,2'b00,1,1,0,1,1,1,1,0);
        // R2 shared L1 line, in L3
        drive(1,1,2'b00,1,0,1,1,1,1,1,0);
        // R2 with R4 alloc: miss all, interconnect not hub
        drive(1,0,2'b00,0,0,0,0,0,1,1,0);
        // R3 interconnect far
        drive(1,0,2'b00,0,0,0,0,1,1,1,0);
        // R5 device with support, hub clear
        drive(1,1,2'b01,0,0,0,0,0,1,1,0);
        // R6 load abort
        drive(1,0,2'b10,0,0,0,0,1,0,1,0);
        // R7 store abort, then hold pending
        drive(1,1,2'b11,0,0,0,0,1,0,1,0);
        drive(0,0,2'b00,0,0,0,0,0,0,1,0);
        drive(0,0,2'b00,0,0,0,0,0,0,1,0);
        // R7 ack clears
        drive(0,0,2'b00,0,0,0,0,0,0,1,1);
        drive(0,0,2'b00,0,0,0,0,0,0,1,0);
        // R7 set and ack together: set wins
        drive(1,1,2'b01,0,0,0,0,0,0,1,1);
        drive(0,0,2'b00,0,0,0,0,0,0,1,1);
        drive(0,0,2'b00,0,0,0,0,0,0,1,0);
        // R9 stall: response held, new request refused
        drive(1,0,2'b00,0,0,1,0,1,1,0,0);
        drive(1,0,2'b00,1,1,0,0,1,1,0,0);
        drive(1,0,2'b00,1,1,0,0,1,1,0,0);
        drive(1,0,2'b00,1,1,0,0,1,1,1,0);
        drive(0,0,2'b00,0,0,0,0,0,0,1,0);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [10:0] r = 11'($urandom);
            drive(r[0], r[1], r[3:2], r[4], r[5], r[6], r[7],
                  ($urandom_range(0,3) != 0), r[8], r[9] | r[10], ($urandom_range(0,7) == 0));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule